// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

This block collects up to eight interrupt request lines, applies a mask to each line and resolves them by fixed priority into one interrupt output. Software reaches it through a byte-wide register port with two addresses. Address 0 takes commands and returns status: the request register, the in-service register, or a poll word. Address 1 takes the mask and the three words of the setup sequence. An interrupt is acknowledged by arming a poll and then reading address 0. That read names the winning line and marks it in service. A specific end-of-interrupt command later clears the in-service mark.

A parameter sets the instance's role. In the master role, the lines named in the setup's cascade bitmap are treated as level requests, because each one carries the interrupt output of a slave instance. A slave output can stay high across several acknowledges, so the master must see it again without a new edge. Software polls the master first. If the master answers line 2, software polls the slave, and the final level is the slave's answer plus 8. Each line whose poll returns no valid request gets the spurious answer 7 with bit 7 clear, and no in-service bit is set.

Top module: `pic_channel`

## Requirements
- R1: After reset, the mask reads back 0xFF at address 1, address-0 reads return the request register, no line is in service and `irqOut` is low.
- R2: Writing a command byte with bit 4 set (0x11) to address 0 starts setup. The next three address-1 writes are taken as the setup words (base, cascade word, mode), and none of them reaches the mask. Setup clears the mask to 0x00 and clears every in-service bit.
- R3: A rising edge on a non-cascade line is latched and stays pending while the line stays high, even if the line is masked, until that line is acknowledged. A line still held high after its acknowledge makes no new request. The request register shows a bit for each line that is latched and still high.
- R4: A set mask bit stops its line from raising `irqOut` or winning a poll. With a mask of 0xFF, `irqOut` stays low for every request pattern. Address-1 reads return the mask last written.
- R5: Priority is fixed, with line 0 highest. After 0x0C is written to address 0, the next address-0 read returns 0x80 plus the highest-priority unmasked pending level in bits 2:0, and sets that line's in-service bit.
- R6: `irqOut` is high only while some unmasked pending line has higher priority than every line in service. A lower-priority request waits until the in-service bit above it is cleared.
- R7: Writing 0x60+n to address 0 clears in-service bit n and no other bit.
- R8: A poll read with no valid request returns 0x07 (bit 7 clear) and leaves the in-service register unchanged.
- R9: Writing 0x0A to address 0 selects the request register for later address-0 reads. Writing 0x0B selects the in-service register.
- R10: In the master role, lines marked in the cascade word are level-sensitive. With a slave on line 2, software polls the master (answer 2) and then the slave (answer n, final level 8+n). It sends end-of-interrupt to the slave first and then 0x62 to the master. If another slave request is still pending, the master raises `irqOut` again without a new edge.
- R11: An armed poll serves exactly one address-0 read. The address-0 read after it returns the selected register again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address: 0 command/status, 1 mask/setup |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe; a poll read acknowledges on this cycle's edge |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte for the current address, combinational |
| reqIn | input | 8 | Interrupt request lines, bit 0 highest priority |
| irqOut | output | 1 | Interrupt to the processor, or to the master when used as a slave |

## Verification
The priority sweep applies every request pattern that leaves the cascade line clear. It polls each pattern down through its lines in order, which separates a wrong priority order from wrong nesting, because a blocked lower line must stay silent until the end-of-interrupt above it. The mask sweep holds the same request pattern against all 256 masks, which separates masking from priority and confirms the spurious answer when every request is masked. Single-line cases with the line held high separate edge latching from level sensing. The master-slave chain, with two slave requests, shows that a cascade line re-requests from its level alone.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_LINES = 8;
  localparam int LVL_W     = $clog2(NUM_LINES);
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic             initStart;
    logic             cascWr;
    logic             maskWr;
    logic             pollTake;
    logic             eoi;
    logic [LVL_W-1:0] eoiLevel;
  } picStrobe_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output picStrobe_t        strb,
  output logic              readIsr,
  output logic              pollArmed
);
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} setupSt_t;
  setupSt_t setupSt;

  logic cmdWr, dataWr, isInit, isOcw3, isOcw2;

  always_comb begin
    cmdWr  = wrEn && !addr;
    dataWr = wrEn && addr;
    isInit = cmdWr && wrData[4];
    isOcw3 = cmdWr && !wrData[4] && wrData[3];
    isOcw2 = cmdWr && !wrData[4] && !wrData[3];
    strb.initStart = isInit;
    strb.cascWr    = dataWr && (setupSt == ST_CASC);
    strb.maskWr    = dataWr && (setupSt == ST_RUN);
    strb.pollTake  = rdEn && !addr && pollArmed;
    strb.eoi       = isOcw2 && (wrData[7:5] == 3'b011);
    strb.eoiLevel  = wrData[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupSt <= ST_RUN;
    end else if (isInit) begin
      setupSt <= ST_BASE;
    end else if (dataWr) begin
      case (setupSt)
        ST_BASE: setupSt <= ST_CASC;
        ST_CASC: setupSt <= ST_MODE;
        ST_MODE: setupSt <= ST_RUN;
        default: setupSt <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || isInit) begin
      readIsr   <= 1'b0;
      pollArmed <= 1'b0;
    end else begin
      if (isOcw3 && wrData[1]) readIsr <= wrData[0];
      if (isOcw3 && wrData[2]) pollArmed <= 1'b1;
      else if (strb.pollTake)  pollArmed <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] reqIn,
  input  picStrobe_t           strb,
  input  logic                 readIsr,
  input  logic                 pollArmed,
  output logic                 irqOut,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_LINES-1:0] isrVec,
  output logic [NUM_LINES-1:0] maskVec
);
  logic [NUM_LINES-1:0] prevIn, edgeLatch, cascMap, pending, active;
  logic [NUM_LINES-1:0] ackMask, eoiMask, isrQ, maskQ;
  logic [LVL_W:0]       reqFind, isrFind;
  logic [LVL_W-1:0]     reqLvl;
  logic                 reqValid;
  logic [DATA_W-1:0]    pollWord, cmdRead;

  function automatic logic [LVL_W:0] findLowest(input logic [NUM_LINES-1:0] v);
    findLowest = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (v[i]) findLowest = {1'b1, LVL_W'(i)};
  endfunction

  generate
    if (IS_MASTER) begin : g_master
      always_ff @(posedge clk) begin
        if (!rstN || strb.initStart) cascMap <= '0;
        else if (strb.cascWr)        cascMap <= wrData[NUM_LINES-1:0];
      end
    end else begin : g_slave
      assign cascMap = '0;
    end
  endgenerate

  always_comb begin
    pending  = (cascMap & reqIn) | (~cascMap & edgeLatch & reqIn);
    active   = pending & ~maskQ;
    reqFind  = findLowest(active);
    isrFind  = findLowest(isrQ);
    reqLvl   = reqFind[LVL_W-1:0];
    reqValid = reqFind[LVL_W] && (!isrFind[LVL_W] || (reqLvl < isrFind[LVL_W-1:0]));
    ackMask  = (strb.pollTake && reqValid) ? (NUM_LINES'(1) << reqLvl) : '0;
    eoiMask  = strb.eoi ? (NUM_LINES'(1) << strb.eoiLevel) : '0;
    pollWord = reqValid ? {1'b1, {(DATA_W-1-LVL_W){1'b0}}, reqLvl} : DATA_W'(NUM_LINES - 1);
    cmdRead  = pollArmed ? pollWord : (readIsr ? isrQ : pending);
    rdData   = addr ? maskQ : cmdRead;
    irqOut   = reqValid;
    isrVec   = isrQ;
    maskVec  = maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn    <= '0;
      edgeLatch <= '0;
      isrQ      <= '0;
      maskQ     <= '1;
    end else begin
      prevIn <= reqIn;
      if (strb.initStart) begin
        edgeLatch <= '0;
        isrQ      <= '0;
        maskQ     <= '0;
      end else begin
        edgeLatch <= (edgeLatch | (reqIn & ~prevIn)) & ~ackMask;
        isrQ      <= (isrQ | ackMask) & ~eoiMask;
        if (strb.maskWr) maskQ <= wrData[NUM_LINES-1:0];
      end
    end
  end
endmodule

// File: rtl/pic_channel.sv
module pic_channel
  import pic_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addr,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] reqIn,
  output logic                 irqOut
);
  picStrobe_t           strb;
  logic                 readIsr, pollArmed;
  logic [NUM_LINES-1:0] isrVec, maskVec;

  pic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .strb(strb), .readIsr(readIsr), .pollArmed(pollArmed)
  );

  pic_datapath #(.IS_MASTER(IS_MASTER)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .reqIn(reqIn),
    .strb(strb), .readIsr(readIsr), .pollArmed(pollArmed), .irqOut(irqOut),
    .rdData(rdData), .isrVec(isrVec), .maskVec(maskVec)
  );
endmodule

// File: rtl/pic_channel_chk.sv
module pic_channel_chk
  import pic_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 irqOut,
  input picStrobe_t           strb,
  input logic                 pollArmed,
  input logic [NUM_LINES-1:0] isrVec,
  input logic [NUM_LINES-1:0] maskVec
);
  // R2
  setup_clears_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.initStart |=> (maskVec == '0 && isrVec == '0));

  // R4
  full_mask_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '1) |-> !irqOut);

  // R5
  ack_sets_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pollTake && irqOut && !strb.eoi) |=>
      ($countones(isrVec) == $past($countones(isrVec)) + 1));

  // R7
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !strb.pollTake && !strb.initStart) |=> !isrVec[$past(strb.eoiLevel)]);

  // R8
  spurious_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pollTake && !irqOut && !strb.eoi && !strb.initStart) |=> $stable(isrVec));

  // R11
  poll_oneshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pollTake && !strb.initStart) |=> !pollArmed);
endmodule

bind pic_channel pic_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .strb(strb),
  .pollArmed(pollArmed), .isrVec(isrVec), .maskVec(maskVec)
);

// File: tb/pic_channel_tb.sv
module pic_channel_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWd = 8'h00;
  logic       mWr = 1'b0, mRd = 1'b0, sWr = 1'b0, sRd = 1'b0;
  logic [7:0] mReq = 8'h00, sReq = 8'h00;
  logic [7:0] mRdData, sRdData, mIn;
  logic       mIrq, sIrq;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign mIn = {mReq[7:3], sIrq, mReq[1:0]};

  pic_channel #(.IS_MASTER(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wrEn(mWr), .rdEn(mRd),
    .wrData(busWd), .rdData(mRdData), .reqIn(mIn), .irqOut(mIrq)
  );

  pic_channel #(.IS_MASTER(1'b0)) u_slave (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wrEn(sWr), .rdEn(sRd),
    .wrData(busWd), .rdData(sRdData), .reqIn(sReq), .irqOut(sIrq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input bit toSlave, input bit a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWd = d;
    if (toSlave) sWr = 1'b1; else mWr = 1'b1;
    @(negedge clk);
    mWr = 1'b0; sWr = 1'b0;
  endtask

  task automatic rdReg(input bit toSlave, input bit a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    if (toSlave) sRd = 1'b1; else mRd = 1'b1;
    #1 d = toSlave ? sRdData : mRdData;
    @(negedge clk);
    mRd = 1'b0; sRd = 1'b0;
  endtask

  task automatic poll(input bit toSlave, output logic [7:0] d);
    wrReg(toSlave, 1'b0, 8'h0C);
    rdReg(toSlave, 1'b0, d);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rdReg(0, 1, d); check("R1 mask after reset", d, 8'hFF);
    rdReg(0, 0, d); check("R1 request register after reset", d, 8'h00);
    check("R1 irq after reset", {7'd0, mIrq}, 8'h00);
    // R4 all requests masked by reset mask
    mReq = 8'hFB; idle(3);
    check("R4 full mask blocks", {7'd0, mIrq}, 8'h00);
    mReq = 8'h00; idle(1);

    // R2 setup sequences
    wrReg(0, 0, 8'h11); wrReg(0, 1, 8'h00); wrReg(0, 1, 8'h04); wrReg(0, 1, 8'h01);
    rdReg(0, 1, d); check("R2 master mask after setup", d, 8'h00);
    wrReg(1, 0, 8'h11); wrReg(1, 1, 8'h08); wrReg(1, 1, 8'h02); wrReg(1, 1, 8'h01);
    rdReg(1, 1, d); check("R2 slave mask after setup", d, 8'h00);

    // R3 R9 single line
    mReq = 8'h20; idle(2);
    wrReg(0, 0, 8'h0A); rdReg(0, 0, d); check("R9 R3 request register", d, 8'h20);
    wrReg(0, 0, 8'h0B); rdReg(0, 0, d); check("R9 in-service register idle", d, 8'h00);
    check("R3 irq on edge", {7'd0, mIrq}, 8'h01);
    wrReg(0, 1, 8'h20); idle(1);
    check("R4 masked line", {7'd0, mIrq}, 8'h00);
    wrReg(0, 1, 8'h00); idle(1);
    check("R3 latch survives mask", {7'd0, mIrq}, 8'h01);
    poll(0, d); check("R5 poll line 5", d, 8'h85);
    rdReg(0, 0, d); check("R11 read after poll is ISR", d, 8'h20);
    check("R3 no request after ack", {7'd0, mIrq}, 8'h00);
    wrReg(0, 0, 8'h65);
    rdReg(0, 0, d); check("R7 eoi clears line 5", d, 8'h00);
    check("R3 held line no new request", {7'd0, mIrq}, 8'h00);
    mReq = 8'h00; idle(1);
    poll(0, d); check("R8 spurious poll", d, 8'h07);
    rdReg(0, 0, d); check("R8 ISR unchanged", d, 8'h00);

    // R5 R6 R7 priority sweep
    for (int p = 0; p < 256; p++) begin
      if (p[2]) continue;
      mReq = 8'h00; idle(1);
      mReq = p[7:0]; idle(2);
      check("R6 irq for pattern", {7'd0, mIrq}, {7'd0, p != 0});
      if (p == 0) begin
        poll(0, d); check("R8 empty pattern poll", d, 8'h07);
      end
      for (int b = 0; b < 8; b++) begin
        if (!p[b]) continue;
        poll(0, d); check("R5 priority order", d, 8'h80 | 8'(b));
        if ((p >> (b + 1)) != 0) begin
          check("R6 lower line waits", {7'd0, mIrq}, 8'h00);
        end
        wrReg(0, 0, 8'h60 | 8'(b));
      end
      check("R6 irq after all serviced", {7'd0, mIrq}, 8'h00);
      rdReg(0, 0, d); check("R7 ISR empty after sweep step", d, 8'h00);
    end
    mReq = 8'h00;

    // R4 mask sweep
    for (int m = 0; m < 256; m++) begin
      int lo;
      logic [7:0] eff;
      wrReg(0, 1, m[7:0]);
      mReq = 8'h00; idle(1);
      mReq = 8'hFB; idle(2);
      eff = 8'hFB & ~m[7:0];
      lo = 8;
      for (int i = 7; i >= 0; i--) if (eff[i]) lo = i;
      check("R4 irq under mask", {7'd0, mIrq}, {7'd0, eff != 0});
      rdReg(0, 1, d); check("R4 mask readback", d, m[7:0]);
      poll(0, d);
      if (eff != 0) begin
        check("R4 masked poll", d, 8'h80 | 8'(lo));
        wrReg(0, 0, 8'h60 | 8'(lo));
      end else begin
        check("R4 R8 all masked poll", d, 8'h07);
      end
      mReq = 8'h00;
    end
    wrReg(0, 1, 8'h00); idle(2);

    // R10 cascade chain
    sReq = 8'h48; idle(3);
    check("R10 master sees slave", {7'd0, mIrq}, 8'h01);
    poll(0, d); check("R10 master answers 2", d, 8'h82);
    poll(1, d); check("R10 slave level 11", 8'(d[2:0]) + 8'd8, 8'd11);
    check("R10 master blocked during service", {7'd0, mIrq}, 8'h00);
    wrReg(1, 0, 8'h63); idle(1);
    check("R10 slave re-requests", {7'd0, sIrq}, 8'h01);
    check("R10 master waits for its eoi", {7'd0, mIrq}, 8'h00);
    wrReg(0, 0, 8'h62); idle(1);
    check("R10 master level re-request", {7'd0, mIrq}, 8'h01);
    poll(0, d); check("R10 master answers 2 again", d, 8'h82);
    poll(1, d); check("R10 slave level 14", 8'(d[2:0]) + 8'd8, 8'd14);
    wrReg(1, 0, 8'h66); wrReg(0, 0, 8'h62); idle(1);
    check("R10 slave quiet", {7'd0, sIrq}, 8'h00);
    check("R10 master quiet", {7'd0, mIrq}, 8'h00);
    sReq = 8'h00; idle(2);

    finish();
  end
endmodule